// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Command Engine

This block lets a processor read and program a one-time-programmable (OTP) array through a small register bus. The processor fills an operand register set: a command code, a row address and one or two 32-bit data words. It then raises a start bit. The engine executes the command while the start bit is held. When the command finishes it raises a done flag, and that flag stays up until software lowers the start bit again. The array is a behavioural model. Every row holds `WPR` words of 32 bits, and every bit starts at zero. Programming can only turn bits on. The time a program takes grows with the number of bits that change from 0 to 1.

Programming is locked after reset. To unlock it, software must complete four unlock commands in a row, with the data values 0xF, 0x4, 0x8 and 0xD in that order. A lock command closes programming again.

The controller is a three-state machine with these states:
- `ST_IDLE`: waits for a launch.
- `ST_BUSY`: counts down the latency of the current command.
- `ST_DONE`: holds the done flag.

It has three transitions:
- launch (`ST_IDLE`→`ST_BUSY`): the access-enable bit and the start bit are both set.
- finish (`ST_BUSY`→`ST_DONE`): the countdown reaches zero, and the command takes effect in that cycle.
- release (`ST_DONE`→`ST_IDLE`): the start bit reads zero.

Top module: `otp_cmd_engine`

## Requirements
- R1: After reset, every register reads zero, the status reads zero, and every array bit is zero.
- R2: Register offsets are:

  | Offset | Register | Stored bits |
  |--------|----------|-------------|
  | 0x00 | access enable | bit 0 only |
  | 0x04 | command | 6 bits |
  | 0x08 | start | bit 0 only |
  | 0x0C | status | bit 1 = done, bit 2 = programming enabled |
  | 0x28 | row address | low 16 bits |
  | 0x2C | data word 0 | 32 bits |
  | 0x64 | data word 1 | 32 bits |
  | 0x10 | read word 0 | read only |
  | 0x5C | read word 1 | read only |

  Each register reads back only the bits it stores.
- R3: While access-enable bit 0 is clear, a set start bit launches nothing and done stays 0.
- R4: A command launches on the first clock edge at which the engine is idle and both the enable bit and the start bit are set. It stays busy for its latency L. Done is visible L+1 edges after the edge that wrote the start bit. Done stays set while the start bit is held, and the same command does not launch again. Done clears on the second edge after the start bit is written to 0.
- R5: Command 0x00 reads a row with latency `READ_LAT`. The row's words appear in read word 0 and read word 1.
- R6: Four unlock commands (0x02), issued back to back with data word 0 equal to 0xF, 0x4, 0x8 and 0xD in that order, set status bit 2. Each of these commands has latency 1.
- R7: The unlock sequence restarts from its first step when an unlock command carries the wrong value, or when any other command completes partway through the sequence.
- R8: The lock command (0x03) clears status bit 2 and has latency 1.
- R9: A program command (0x0A) issued while programming is locked completes after `PROG_BASE` cycles and leaves the array unchanged.
- R10: A program command issued while programming is enabled ORs the data words into the row. Its latency is `PROG_BASE` plus `PROG_PER_BIT` for each bit that goes from 0 to 1.
- R11: Any other command code completes with latency 1 and has no effect on the array, the read words or status bit 2.
- R12: The array row is selected by the low log2(`ROWS`) bits of the row address, and the higher address bits are ignored.
- R13: The command, the address and the data words are captured at launch. Bus writes to them while the engine is busy do not change the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |

## Verification
The assertions on unlock and lock assume that a command completes at most once per finish pulse. They also assume that the unlock key is judged against the captured data word 0, not against the live register. The bench respects this because it only changes operands while a command is running in the deliberate capture test. The bit-only-set assertion holds only if reset is held for at least one edge. The bench holds reset for several edges. The bench drives every bus access at the falling clock edge, so each access stays stable across exactly one rising edge. A behavioural model mirrors each register and each array row, and it is compared against the read-data port on every cycle.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_DONE
    } eng_state_t;

    localparam int          DW     = 32;
    localparam int          BUS_AW = 8;

    localparam logic [5:0]  OP_READ   = 6'h00;
    localparam logic [5:0]  OP_UNLOCK = 6'h02;
    localparam logic [5:0]  OP_LOCK   = 6'h03;
    localparam logic [5:0]  OP_PROG   = 6'h0A;

    localparam logic [BUS_AW-1:0] A_MODE = 8'h00;
    localparam logic [BUS_AW-1:0] A_CMD  = 8'h04;
    localparam logic [BUS_AW-1:0] A_GO   = 8'h08;
    localparam logic [BUS_AW-1:0] A_STAT = 8'h0C;
    localparam logic [BUS_AW-1:0] A_RD0  = 8'h10;
    localparam logic [BUS_AW-1:0] A_ADDR = 8'h28;
    localparam logic [BUS_AW-1:0] A_WD0  = 8'h2C;
    localparam logic [BUS_AW-1:0] A_RD1  = 8'h5C;
    localparam logic [BUS_AW-1:0] A_WD1  = 8'h64;

    function automatic logic [DW-1:0] unlock_key(input logic [1:0] idx);
        unique case (idx)
            2'd0: unlock_key = 32'h0000_000F;
            2'd1: unlock_key = 32'h0000_0004;
            2'd2: unlock_key = 32'h0000_0008;
            2'd3: unlock_key = 32'h0000_000D;
        endcase
    endfunction

    function automatic logic [BUS_AW-1:0] wd_offset(input int w);
        wd_offset = (w == 0) ? A_WD0 : A_WD1;
    endfunction

    function automatic logic [BUS_AW-1:0] rd_offset(input int w);
        rd_offset = (w == 0) ? A_RD0 : A_RD1;
    endfunction

endpackage

// File: rtl/otp_unlock_tracker.sv
module otp_unlock_tracker
    import otp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_v,
    input  logic [5:0]    op,
    input  logic [DW-1:0] key_in,
    output logic          prog_ok
);

    logic [1:0] step_q;
    logic       ok_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= 2'd0;
            ok_q   <= 1'b0;
        end else if (step_v) begin
            if (op == OP_UNLOCK) begin
                if (key_in == unlock_key(step_q)) begin
                    if (step_q == 2'd3) begin
                        ok_q   <= 1'b1;
                        step_q <= 2'd0;
                    end else begin
                        step_q <= step_q + 2'd1;
                    end
                end else begin
                    step_q <= 2'd0;
                end
            end else if (op == OP_LOCK) begin
                ok_q   <= 1'b0;
                step_q <= 2'd0;
            end else begin
                step_q <= 2'd0;
            end
        end
    end

    assign prog_ok = ok_q;

    // R6: enable only follows a completed final key step
    a_r6_grant_after_last_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_q) |-> ($past(step_q) == 2'd3 && $past(step_v) && $past(op) == OP_UNLOCK));

    // R6: nothing moves the enable without a completing command
    a_r6_ok_stable_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !step_v |=> $stable(ok_q));

    // R7: a foreign command restarts the sequence
    a_r7_foreign_cmd_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (step_v && op != OP_UNLOCK) |=> (step_q == 2'd0));

    // R8: lock always leaves programming disabled
    a_r8_lock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (step_v && op == OP_LOCK) |=> !ok_q);

endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
    import otp_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int WPR  = 2,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int RDW  = WPR * DW,
    localparam int FB_W = $clog2(RDW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   row_idx,
    input  logic            wr_en,
    input  logic [RDW-1:0]  wr_data,
    output logic [RDW-1:0]  rd_data,
    output logic [FB_W-1:0] fresh_bits
);

    logic [RDW-1:0] cells [ROWS];
    logic [RDW-1:0] newb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) cells[i] <= '0;
        end else if (wr_en) begin
            cells[row_idx] <= cells[row_idx] | wr_data;
        end
    end

    assign rd_data = cells[row_idx];
    assign newb    = wr_data & ~rd_data;

    always_comb begin
        fresh_bits = '0;
        for (int i = 0; i < RDW; i++) fresh_bits = fresh_bits + FB_W'(newb[i]);
    end

    genvar g;
    generate
        for (g = 0; g < ROWS; g++) begin : g_row_chk
            // R10: a programmed bit never returns to zero
            a_r10_bits_only_set: assert property (@(posedge clk) disable iff (!rst_n)
                (($past(cells[g]) & ~cells[g]) == '0));
        end
    endgenerate

endmodule

// File: rtl/otp_cmd_engine.sv
module otp_cmd_engine
    import otp_pkg::*;
#(
    parameter int ROWS         = 16,
    parameter int WPR          = 2,
    parameter int READ_LAT     = 3,
    parameter int PROG_BASE    = 4,
    parameter int PROG_PER_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata
);

    localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int RDW     = WPR * DW;
    localparam int FB_W    = $clog2(RDW + 1);
    localparam int MAX_LAT = PROG_BASE + PROG_PER_BIT * RDW + READ_LAT + 1;
    localparam int LAT_W   = $clog2(MAX_LAT + 1);

    // software-visible registers
    logic           mode_q;
    logic [5:0]     cmd_q;
    logic           go_q;
    logic [15:0]    addr_q;
    logic [RDW-1:0] wd_q;
    logic [RDW-1:0] rd_q;

    // captured operation
    logic [5:0]     op_cmd_q;
    logic [RW-1:0]  op_row_q;
    logic [RDW-1:0] op_wd_q;

    eng_state_t     state_q, state_d;
    logic [LAT_W-1:0] cnt_q, cnt_d;

    logic           launch, finish;
    logic           prog_ok;
    logic [RW-1:0]  row_sel;
    logic [RDW-1:0] arr_wdata, arr_rd;
    logic [FB_W-1:0] fresh;
    logic           arr_wr;
    logic           done;
    int             lat_i;

    // ---------------- register writes ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            cmd_q  <= '0;
            go_q   <= 1'b0;
            addr_q <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                A_MODE:  mode_q <= bus_wdata[0];
                A_CMD:   cmd_q  <= bus_wdata[5:0];
                A_GO:    go_q   <= bus_wdata[0];
                A_ADDR:  addr_q <= bus_wdata[15:0];
                default: ;
            endcase
        end
    end

    genvar w;
    generate
        for (w = 0; w < WPR; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wd_q[w*DW +: DW] <= '0;
                end else if (bus_we && bus_addr == wd_offset(w)) begin
                    wd_q[w*DW +: DW] <= bus_wdata;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rd_q[w*DW +: DW] <= '0;
                end else if (finish && op_cmd_q == OP_READ) begin
                    rd_q[w*DW +: DW] <= arr_rd[w*DW +: DW];
                end
            end
        end
    endgenerate

    // ---------------- array and unlock ----------------
    assign row_sel   = (state_q == ST_IDLE) ? addr_q[RW-1:0] : op_row_q;
    assign arr_wdata = (state_q == ST_IDLE) ? wd_q : op_wd_q;
    assign arr_wr    = finish && op_cmd_q == OP_PROG && prog_ok;

    otp_fuse_array #(
        .ROWS (ROWS),
        .WPR  (WPR)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_idx    (row_sel),
        .wr_en      (arr_wr),
        .wr_data    (arr_wdata),
        .rd_data    (arr_rd),
        .fresh_bits (fresh)
    );

    otp_unlock_tracker u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_v  (finish),
        .op      (op_cmd_q),
        .key_in  (op_wd_q[DW-1:0]),
        .prog_ok (prog_ok)
    );

    // ---------------- controller ----------------
    assign launch = (state_q == ST_IDLE) && mode_q && go_q;
    assign finish = (state_q == ST_BUSY) && (cnt_q == '0);

    always_comb begin
        case (cmd_q)
            OP_READ: lat_i = READ_LAT;
            OP_PROG: lat_i = prog_ok ? (PROG_BASE + PROG_PER_BIT * int'(fresh)) : PROG_BASE;
            default: lat_i = 1;
        endcase
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: if (launch) begin
                state_d = ST_BUSY;
                cnt_d   = LAT_W'(lat_i - 1);
            end
            ST_BUSY: if (cnt_q == '0) state_d = ST_DONE;
                     else             cnt_d   = cnt_q - 1'b1;
            ST_DONE: if (!go_q) state_d = ST_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            op_cmd_q <= '0;
            op_row_q <= '0;
            op_wd_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (launch) begin
                op_cmd_q <= cmd_q;
                op_row_q <= addr_q[RW-1:0];
                op_wd_q  <= wd_q;
            end
        end
    end

    // output process
    always_comb begin
        done      = (state_q == ST_DONE);
        bus_rdata = '0;
        case (bus_addr)
            A_MODE: bus_rdata = {31'd0, mode_q};
            A_CMD:  bus_rdata = {26'd0, cmd_q};
            A_GO:   bus_rdata = {31'd0, go_q};
            A_STAT: bus_rdata = {29'd0, prog_ok, done, 1'b0};
            A_ADDR: bus_rdata = {16'd0, addr_q};
            default: ;
        endcase
        for (int k = 0; k < WPR; k++) begin
            if (bus_addr == wd_offset(k)) bus_rdata = wd_q[k*DW +: DW];
            if (bus_addr == rd_offset(k)) bus_rdata = rd_q[k*DW +: DW];
        end
    end

    // R3: no launch while access is disabled
    a_r3_idle_without_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !mode_q) |=> (state_q == ST_IDLE));

    // R4: done is held as long as start stays set
    a_r4_done_held_by_go: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && go_q) |=> (state_q == ST_DONE));

    // R4: done is only reached through a busy phase
    a_r4_no_skip_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q != ST_DONE));

    // R9: a locked program leaves the target row untouched
    a_r9_locked_prog_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && op_cmd_q == OP_PROG && !prog_ok) |=> $stable(arr_rd));

    // R13: captured operands hold while busy
    a_r13_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |=> ($stable(op_cmd_q) && $stable(op_row_q) && $stable(op_wd_q)));

endmodule

// File: tb/otp_cmd_engine_tb.sv
`timescale 1ns/100ps
module otp_cmd_engine_tb;
    import otp_pkg::*;

    localparam int ROWS = 16;
    localparam int WPR  = 2;
    localparam int RLAT = 3;
    localparam int PB   = 4;
    localparam int PPB  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    always #2 clk = ~clk;

    otp_cmd_engine #(
        .ROWS(ROWS), .WPR(WPR), .READ_LAT(RLAT), .PROG_BASE(PB), .PROG_PER_BIT(PPB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference ----------------
    logic [31:0] m_arr [ROWS][WPR];
    logic [31:0] m_wd [WPR];
    logic [31:0] m_rd [WPR];
    logic [31:0] o_wd [WPR];
    logic        m_mode, m_go, m_ok;
    logic [5:0]  m_cmd, o_cmd;
    logic [15:0] m_addr;
    int          o_row, m_step, m_phase, m_rem;

    function automatic logic [31:0] key_of(input int s);
        case (s)
            0: return 32'hF;
            1: return 32'h4;
            2: return 32'h8;
            default: return 32'hD;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return {31'd0, m_mode};
            8'h04: return {26'd0, m_cmd};
            8'h08: return {31'd0, m_go};
            8'h0C: return {29'd0, m_ok, (m_phase == 2), 1'b0};
            8'h28: return {16'd0, m_addr};
            8'h2C: return m_wd[0];
            8'h64: return m_wd[1];
            8'h10: return m_rd[0];
            8'h5C: return m_rd[1];
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_go = 0; m_ok = 0; m_cmd = 0; m_addr = 0;
            m_step = 0; m_phase = 0; m_rem = 0; o_cmd = 0; o_row = 0;
            for (int r = 0; r < ROWS; r++)
                for (int w = 0; w < WPR; w++) m_arr[r][w] = 0;
            for (int w = 0; w < WPR; w++) begin m_wd[w] = 0; m_rd[w] = 0; o_wd[w] = 0; end
        end else begin
            if (m_phase == 0) begin
                if (m_mode && m_go) begin
                    int lat;
                    int row;
                    row = m_addr % ROWS;
                    if (m_cmd == 6'h00) lat = RLAT;
                    else if (m_cmd == 6'h0A) begin
                        lat = PB;
                        if (m_ok)
                            for (int w = 0; w < WPR; w++)
                                lat += PPB * $countones(m_wd[w] & ~m_arr[row][w]);
                    end else lat = 1;
                    o_cmd = m_cmd; o_row = row;
                    for (int w = 0; w < WPR; w++) o_wd[w] = m_wd[w];
                    m_phase = 1; m_rem = lat - 1;
                end
            end else if (m_phase == 1) begin
                if (m_rem == 0) begin
                    m_phase = 2;
                    if (o_cmd == 6'h00)
                        for (int w = 0; w < WPR; w++) m_rd[w] = m_arr[o_row][w];
                    if (o_cmd == 6'h0A && m_ok)
                        for (int w = 0; w < WPR; w++) m_arr[o_row][w] = m_arr[o_row][w] | o_wd[w];
                    if (o_cmd == 6'h02) begin
                        if (o_wd[0] == key_of(m_step)) begin
                            if (m_step == 3) begin m_ok = 1; m_step = 0; end
                            else m_step++;
                        end else m_step = 0;
                    end else if (o_cmd == 6'h03) begin
                        m_ok = 0; m_step = 0;
                    end else m_step = 0;
                end else m_rem--;
            end else begin
                if (!m_go) m_phase = 0;
            end
            if (bus_we) begin
                case (bus_addr)
                    8'h00: m_mode = bus_wdata[0];
                    8'h04: m_cmd  = bus_wdata[5:0];
                    8'h08: m_go   = bus_wdata[0];
                    8'h28: m_addr = bus_wdata[15:0];
                    8'h2C: m_wd[0] = bus_wdata;
                    8'h64: m_wd[1] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #1.5;
        if (rst_n) begin
            n_chk++;
            if (bus_rdata !== m_read(bus_addr)) begin
                n_fail++;
                $display("FAIL %s model compare addr=%h actual=%h expected=%h",
                         cur_req, bus_addr, bus_rdata, m_read(bus_addr));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- tasks ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        @(negedge clk);
    endtask

    task automatic wait_done(output int n);
        logic [31:0] s;
        n = 0;
        do begin
            n++;
            reg_rd(A_STAT, s);
        end while (!s[1] && n < 400);
    endtask

    task automatic release_go(input string req);
        logic [31:0] s;
        reg_wr(A_GO, 0);
        reg_rd(A_STAT, s);
        chk({req, " R4 done held one edge"}, {31'd0, s[1]}, 32'd1);
        reg_rd(A_STAT, s);
        chk({req, " R4 done cleared"}, {31'd0, s[1]}, 32'd0);
    endtask

    task automatic run_cmd(input logic [5:0] c, input int lat, input string req);
        int n;
        cur_req = req;
        reg_wr(A_CMD, {26'd0, c});
        reg_wr(A_GO, 1);
        wait_done(n);
        chk({req, " latency"}, n, lat + 2);
        release_go(req);
    endtask

    task automatic row_read(input logic [15:0] a, output logic [31:0] w0, output logic [31:0] w1);
        reg_wr(A_ADDR, {16'd0, a});
        run_cmd(OP_READ, RLAT, "R5");
        reg_rd(A_RD0, w0);
        reg_rd(A_RD1, w1);
    endtask

    task automatic unlock_step(input logic [31:0] v, input string req);
        reg_wr(A_WD0, v);
        run_cmd(OP_UNLOCK, 1, req);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v, w0, w1;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cur_req = "R1";
        reg_rd(A_MODE, v); chk("R1 mode", v, 0);
        reg_rd(A_STAT, v); chk("R1 status", v, 0);
        reg_rd(A_WD0, v);  chk("R1 data0", v, 0);
        reg_rd(A_RD1, v);  chk("R1 read1", v, 0);

        // R2 field widths
        cur_req = "R2";
        reg_wr(A_CMD, 32'hFF);        reg_rd(A_CMD, v);  chk("R2 cmd 6 bits", v, 32'h3F);
        reg_wr(A_ADDR, 32'hABCD1234); reg_rd(A_ADDR, v); chk("R2 addr 16 bits", v, 32'h1234);
        reg_wr(A_GO, 32'h3);          reg_rd(A_GO, v);   chk("R2 go bit0", v, 32'h1);
        reg_wr(A_GO, 0);
        reg_wr(A_WD1, 32'h5A5A0001);  reg_rd(A_WD1, v);  chk("R2 data1", v, 32'h5A5A0001);
        reg_wr(A_MODE, 32'hFFFF);     reg_rd(A_MODE, v); chk("R2 mode bit0", v, 32'h1);

        // R3 disabled access
        cur_req = "R3";
        reg_wr(A_MODE, 0);
        reg_wr(A_CMD, OP_READ);
        reg_wr(A_GO, 1);
        for (int i = 0; i < 8; i++) begin
            reg_rd(A_STAT, v);
            chk("R3 no done while disabled", {31'd0, v[1]}, 0);
        end
        reg_wr(A_GO, 0);
        reg_wr(A_MODE, 1);

        // R4 / R5 read of a blank row, done held while go stays set
        cur_req = "R4";
        reg_wr(A_ADDR, 3);
        reg_wr(A_CMD, OP_READ);
        reg_wr(A_GO, 1);
        wait_done(n);
        chk("R4 R5 read latency", n, RLAT + 2);
        for (int i = 0; i < 5; i++) begin
            reg_rd(A_STAT, v);
            chk("R4 done held while go", {31'd0, v[1]}, 1);
        end
        release_go("R4");
        reg_rd(A_RD0, v); chk("R5 blank row", v, 0);

        // R9 program while locked
        reg_wr(A_ADDR, 3);
        reg_wr(A_WD0, 32'hFFFF0000);
        reg_wr(A_WD1, 32'h00000001);
        run_cmd(OP_PROG, PB, "R9");
        row_read(3, w0, w1);
        chk("R9 row unchanged w0", w0, 0);
        chk("R9 row unchanged w1", w1, 0);

        // R7 broken sequences
        unlock_step(32'hF, "R7");
        unlock_step(32'h4, "R7");
        unlock_step(32'h9, "R7");
        unlock_step(32'hD, "R7");
        reg_rd(A_STAT, v); chk("R7 wrong value keeps lock", {31'd0, v[2]}, 0);
        unlock_step(32'hF, "R7");
        unlock_step(32'h4, "R7");
        unlock_step(32'h8, "R7");
        row_read(0, w0, w1);
        unlock_step(32'hD, "R7");
        reg_rd(A_STAT, v); chk("R7 foreign cmd restarts", {31'd0, v[2]}, 0);

        // R6 correct sequence
        unlock_step(32'hF, "R6");
        unlock_step(32'h4, "R6");
        unlock_step(32'h8, "R6");
        reg_rd(A_STAT, v); chk("R6 not yet enabled", {31'd0, v[2]}, 0);
        unlock_step(32'hD, "R6");
        reg_rd(A_STAT, v); chk("R6 enabled", {31'd0, v[2]}, 1);

        // R10 OR programming with per-bit latency
        reg_wr(A_ADDR, 3);
        reg_wr(A_WD0, 32'h000000F0);
        reg_wr(A_WD1, 32'h00000001);
        run_cmd(OP_PROG, PB + PPB * 5, "R10");
        reg_wr(A_WD0, 32'h00000F30);
        run_cmd(OP_PROG, PB + PPB * 4, "R10");
        row_read(3, w0, w1);
        chk("R10 OR word0", w0, 32'h00000FF0);
        chk("R10 OR word1", w1, 32'h00000001);
        reg_wr(A_ADDR, 5);
        reg_wr(A_WD0, 32'hFFFFFFFF);
        reg_wr(A_WD1, 32'hFFFFFFFF);
        run_cmd(OP_PROG, PB + PPB * 64, "R10");

        // R12 upper address bits ignored
        row_read(16'hFFF3, w0, w1);
        chk("R12 alias row 3", w0, 32'h00000FF0);
        row_read(16'h0015, w0, w1);
        chk("R12 alias row 5", w1, 32'hFFFFFFFF);

        // R11 unknown command
        run_cmd(6'h3F, 1, "R11");
        reg_rd(A_STAT, v); chk("R11 enable kept", {31'd0, v[2]}, 1);
        reg_rd(A_RD0, v);  chk("R11 read word kept", v, 32'hFFFFFFFF);

        // R13 operand capture
        cur_req = "R13";
        reg_wr(A_ADDR, 7);
        reg_wr(A_WD0, 32'h1);
        reg_wr(A_WD1, 32'h0);
        reg_wr(A_CMD, OP_PROG);
        reg_wr(A_GO, 1);
        reg_wr(A_WD0, 32'hFFFFFFFF);
        reg_wr(A_ADDR, 9);
        wait_done(n);
        release_go("R13");
        row_read(7, w0, w1);
        chk("R13 captured data row 7", w0, 32'h1);
        row_read(9, w0, w1);
        chk("R13 row 9 untouched", w0, 32'h0);

        // R8 lock
        run_cmd(OP_LOCK, 1, "R8");
        reg_rd(A_STAT, v); chk("R8 lock clears enable", {31'd0, v[2]}, 0);
        reg_wr(A_ADDR, 8);
        reg_wr(A_WD0, 32'hAAAA5555);
        run_cmd(OP_PROG, PB, "R8");
        row_read(8, w0, w1);
        chk("R8 program after lock blocked", w0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule